// File: doc/BRIEF.md
# USB Input Current Limit and Charge Disable Arbiter

This block decides which USB input current limit a charger applies, what limit the second power input gets, and whether the charger is disabled and held in high impedance. It takes four kinds of request: a board strap pin that chooses between a low limit and a high limit, write strobes from the host register interface, an expiry pulse from an external host watchdog, and a chip-disable pin. It drives a limit code for each input, a high-impedance flag, a one-cycle pulse that restarts an external safety timer, and a flag that shows whether the host or the strap currently controls the block.

After reset the strap controls the limit. The strap's level is synchronized and followed continuously. The first host write of any kind moves control to the host. From then on the strap is ignored until the watchdog expires, which gives control back to the strap. The disable pin is synchronized and wins over every host setting in both modes.

Top module: `chg_input_arbiter`

## Requirements
- R1: While reset is held and in the first cycle after it, `host_mode`=0, `usb_lim`=0, `in_lim`=2, `hiz`=0 and `tmr_rst`=0. Limit codes are 0=100 mA, 1=500 mA, 2=1500 mA.
- R2: In default mode a high strap gives `usb_lim`=0 (or 1 when `STRAP_HI_500`=1), three clock edges after the pin changes.
- R3: In default mode a low strap gives `usb_lim`=2, three clock edges after the pin changes.
- R4: A `host_wr` strobe sets `host_mode`=1 on the next edge. Each field whose enable is set in the same strobe is loaded on that edge.
- R5: In host mode, strap changes have no effect on `usb_lim`.
- R6: A `wdog_expire` pulse without a write returns `host_mode` to 0 on the next edge, clears the host disable bit, and reloads `usb_lim` from the synchronized strap on that same edge.
- R7: When `host_wr` and `wdog_expire` arrive in the same cycle, the write wins: the mode is host and the written fields are loaded.
- R8: A high disable pin sets `hiz`=1 three edges after the pin rises. `hiz` returns to 0 three edges after the pin falls if the host disable bit is clear.
- R9: The host disable bit drives `hiz` two edges after it is written, but only in host mode. A high disable pin keeps `hiz`=1 whatever the host writes.
- R10: Each rising edge of the disable pin produces exactly one `tmr_rst` pulse, one cycle long, three edges later, in either mode. A falling edge produces none.
- R11: `in_lim` changes only through a host write of its field, or back to 2 on watchdog expiry. The strap never affects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_pin | input | 1 | Asynchronous strap: high = USB port source, low = adapter |
| dis_pin | input | 1 | Asynchronous chip disable, active high |
| host_wr | input | 1 | One-cycle host register write strobe |
| wr_usb_en | input | 1 | The write carries a USB limit |
| wr_usb_lim | input | LIM_W | USB limit code to load |
| wr_in_en | input | 1 | The write carries a second-input limit |
| wr_in_lim | input | LIM_W | Second-input limit code to load |
| wr_hz_en | input | 1 | The write carries the host disable bit |
| wr_hz | input | 1 | Host disable bit value |
| wdog_expire | input | 1 | One-cycle watchdog expiry pulse |
| usb_lim | output | LIM_W | Active USB input limit code |
| in_lim | output | LIM_W | Active second-input limit code |
| hiz | output | 1 | Charger disabled, high impedance |
| tmr_rst | output | 1 | One-cycle safety timer restart |
| host_mode | output | 1 | 1 = host controls, 0 = strap controls |

## Verification
Host write and watchdog results land on the first edge after the strobe. A host disable bit reaches `hiz` on the second edge. The strap and disable pins pass through two synchronizer flops and an output register, so their results land on the third edge. The bench applies inputs just after a falling clock edge and reads outputs at the falling edge after the counted number of rising edges. For the pin paths it also checks the edge before the result is due, so both early and late changes are caught. The one-cycle pulse is checked in the cycle before it, the cycle it appears, and the cycle after.

// File: rtl/ilim_pkg.sv
package ilim_pkg;
  localparam int LIM_W = 2;
  typedef enum logic [LIM_W-1:0] {
    LIM_100MA  = 2'd0,
    LIM_500MA  = 2'd1,
    LIM_1500MA = 2'd2,
    LIM_RSVD   = 2'd3
  } lim_code_e;
endpackage

// File: rtl/ilim_sync.sv
module ilim_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= RST_VAL;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ilim_owner.sv
module ilim_owner
  import ilim_pkg::*;
#(
  parameter bit STRAP_HI_500 = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strap_s,
  input  logic             host_wr,
  input  logic             wr_usb_en,
  input  logic [LIM_W-1:0] wr_usb_lim,
  input  logic             wr_in_en,
  input  logic [LIM_W-1:0] wr_in_lim,
  input  logic             wr_hz_en,
  input  logic             wr_hz,
  input  logic             wdog_expire,
  output logic             host_mode,
  output logic [LIM_W-1:0] usb_lim,
  output logic [LIM_W-1:0] in_lim,
  output logic             host_hz
);
  localparam lim_code_e STRAP_HI_CODE = STRAP_HI_500 ? LIM_500MA : LIM_100MA;

  logic [LIM_W-1:0] strap_code;
  assign strap_code = strap_s ? STRAP_HI_CODE : LIM_1500MA;

  always_ff @(posedge clk) begin
    if (rst) begin
      host_mode <= 1'b0;
      usb_lim   <= LIM_100MA;
      in_lim    <= LIM_1500MA;
      host_hz   <= 1'b0;
    end else if (host_wr) begin
      host_mode <= 1'b1;
      if (wr_usb_en) usb_lim <= wr_usb_lim;
      if (wr_in_en)  in_lim  <= wr_in_lim;
      if (wr_hz_en)  host_hz <= wr_hz;
    end else if (wdog_expire) begin
      host_mode <= 1'b0;
      usb_lim   <= strap_code;
      in_lim    <= LIM_1500MA;
      host_hz   <= 1'b0;
    end else if (!host_mode) begin
      usb_lim   <= strap_code;
    end
  end

  assert_write_takes_host_R4: assert property (@(posedge clk) disable iff (rst)
    host_wr |=> host_mode);
  assert_expiry_to_default_R6: assert property (@(posedge clk) disable iff (rst)
    (wdog_expire && !host_wr) |=> (!host_mode && !host_hz));
  assert_strap_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (host_mode && !host_wr && !wdog_expire) |=> $stable(usb_lim));
  assert_in_lim_only_host_R11: assert property (@(posedge clk) disable iff (rst)
    (!host_wr && !wdog_expire) |=> $stable(in_lim));
  assert_write_beats_expiry_R7: assert property (@(posedge clk) disable iff (rst)
    (host_wr && wdog_expire) |=> host_mode);
endmodule

// File: rtl/ilim_disable.sv
module ilim_disable (
  input  logic clk,
  input  logic rst,
  input  logic dis_s,
  input  logic host_mode,
  input  logic host_hz,
  output logic hiz,
  output logic tmr_rst
);
  logic dis_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      dis_d   <= 1'b0;
      hiz     <= 1'b0;
      tmr_rst <= 1'b0;
    end else begin
      dis_d   <= dis_s;
      hiz     <= dis_s | (host_mode & host_hz);
      tmr_rst <= dis_s & ~dis_d;
    end
  end

  assert_pulse_one_cycle_R10: assert property (@(posedge clk) disable iff (rst)
    tmr_rst |=> !tmr_rst);
  assert_pin_wins_R9: assert property (@(posedge clk) disable iff (rst)
    dis_s |=> hiz);
  assert_default_ignores_host_bit_R9: assert property (@(posedge clk) disable iff (rst)
    (!dis_s && !host_mode) |=> !hiz);
endmodule

// File: rtl/chg_input_arbiter.sv
module chg_input_arbiter
  import ilim_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter bit STRAP_HI_500 = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strap_pin,
  input  logic             dis_pin,
  input  logic             host_wr,
  input  logic             wr_usb_en,
  input  logic [LIM_W-1:0] wr_usb_lim,
  input  logic             wr_in_en,
  input  logic [LIM_W-1:0] wr_in_lim,
  input  logic             wr_hz_en,
  input  logic             wr_hz,
  input  logic             wdog_expire,
  output logic [LIM_W-1:0] usb_lim,
  output logic [LIM_W-1:0] in_lim,
  output logic             hiz,
  output logic             tmr_rst,
  output logic             host_mode
);
  logic strap_s, dis_s, host_hz;

  ilim_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_strap_sync (
    .clk(clk), .rst(rst), .d(strap_pin), .q(strap_s));

  ilim_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_dis_sync (
    .clk(clk), .rst(rst), .d(dis_pin), .q(dis_s));

  ilim_owner #(.STRAP_HI_500(STRAP_HI_500)) u_owner (
    .clk(clk), .rst(rst), .strap_s(strap_s),
    .host_wr(host_wr), .wr_usb_en(wr_usb_en), .wr_usb_lim(wr_usb_lim),
    .wr_in_en(wr_in_en), .wr_in_lim(wr_in_lim),
    .wr_hz_en(wr_hz_en), .wr_hz(wr_hz), .wdog_expire(wdog_expire),
    .host_mode(host_mode), .usb_lim(usb_lim), .in_lim(in_lim),
    .host_hz(host_hz));

  ilim_disable u_disable (
    .clk(clk), .rst(rst), .dis_s(dis_s), .host_mode(host_mode),
    .host_hz(host_hz), .hiz(hiz), .tmr_rst(tmr_rst));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!host_mode && !hiz && !tmr_rst && usb_lim == LIM_100MA));
endmodule

// File: tb/tb_chg_input_arbiter.sv
module tb_chg_input_arbiter;
  import ilim_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strap_pin = 1'b1, dis_pin = 1'b0;
  logic host_wr = 1'b0, wr_usb_en = 1'b0, wr_in_en = 1'b0, wr_hz_en = 1'b0, wr_hz = 1'b0;
  logic [LIM_W-1:0] wr_usb_lim = '0, wr_in_lim = '0;
  logic wdog_expire = 1'b0;
  logic [LIM_W-1:0] usb_lim, in_lim;
  logic hiz, tmr_rst, host_mode;
  int vectors = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  chg_input_arbiter dut (
    .clk(clk), .rst(rst), .strap_pin(strap_pin), .dis_pin(dis_pin),
    .host_wr(host_wr), .wr_usb_en(wr_usb_en), .wr_usb_lim(wr_usb_lim),
    .wr_in_en(wr_in_en), .wr_in_lim(wr_in_lim), .wr_hz_en(wr_hz_en),
    .wr_hz(wr_hz), .wdog_expire(wdog_expire), .usb_lim(usb_lim),
    .in_lim(in_lim), .hiz(hiz), .tmr_rst(tmr_rst), .host_mode(host_mode));

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic host_write(input bit ue, input int ul, input bit ie, input int il,
                            input bit he, input bit hv, input bit also_wdog);
    host_wr = 1'b1; wr_usb_en = ue; wr_usb_lim = ul[LIM_W-1:0];
    wr_in_en = ie; wr_in_lim = il[LIM_W-1:0]; wr_hz_en = he; wr_hz = hv;
    wdog_expire = also_wdog;
    tick(1);
    host_wr = 1'b0; wr_usb_en = 1'b0; wr_in_en = 1'b0; wr_hz_en = 1'b0;
    wdog_expire = 1'b0;
  endtask

  task automatic expire();
    wdog_expire = 1'b1;
    tick(1);
    wdog_expire = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "host_mode in reset", int'(host_mode), 0);
    chk("R1", "usb_lim in reset", int'(usb_lim), 0);
    chk("R1", "in_lim in reset", int'(in_lim), 2);
    chk("R1", "hiz in reset", int'(hiz), 0);
    chk("R1", "tmr_rst in reset", int'(tmr_rst), 0);
    rst = 1'b0;
    tick(1);
    chk("R1", "host_mode after reset", int'(host_mode), 0);
    chk("R1", "usb_lim after reset", int'(usb_lim), 0);
  endtask

  task automatic t_strap();
    strap_pin = 1'b0;
    tick(2);
    chk("R3", "usb_lim before due", int'(usb_lim), 0);
    tick(1);
    chk("R3", "strap low gives 1500", int'(usb_lim), 2);
    strap_pin = 1'b1;
    tick(2);
    chk("R2", "usb_lim before due", int'(usb_lim), 2);
    tick(1);
    chk("R2", "strap high gives 100", int'(usb_lim), 0);
    chk("R11", "in_lim untouched by strap", int'(in_lim), 2);
  endtask

  task automatic t_host_own();
    host_write(1'b1, 1, 1'b1, 0, 1'b0, 1'b0, 1'b0);
    chk("R4", "host_mode after write", int'(host_mode), 1);
    chk("R4", "usb_lim loaded", int'(usb_lim), 1);
    chk("R11", "in_lim loaded", int'(in_lim), 0);
    strap_pin = 1'b0;
    tick(5);
    chk("R5", "strap ignored in host mode", int'(usb_lim), 1);
    chk("R11", "in_lim ignores strap", int'(in_lim), 0);
    host_write(1'b0, 0, 1'b0, 0, 1'b1, 1'b0, 1'b0);
    chk("R5", "write without usb field keeps limit", int'(usb_lim), 1);
  endtask

  task automatic t_expire();
    expire();
    chk("R6", "mode after expiry", int'(host_mode), 0);
    chk("R6", "usb_lim from strap low", int'(usb_lim), 2);
    chk("R11", "in_lim back to 1500", int'(in_lim), 2);
    strap_pin = 1'b1;
    tick(3);
    chk("R2", "strap followed again", int'(usb_lim), 0);
  endtask

  task automatic t_collide();
    host_write(1'b1, 2, 1'b0, 0, 1'b0, 1'b0, 1'b1);
    chk("R7", "write wins mode", int'(host_mode), 1);
    chk("R7", "write wins limit", int'(usb_lim), 2);
    expire();
    chk("R7", "expiry alone returns default", int'(host_mode), 0);
  endtask

  task automatic t_dis_default();
    dis_pin = 1'b1;
    tick(2);
    chk("R10", "no pulse before due", int'(tmr_rst), 0);
    chk("R8", "hiz before due", int'(hiz), 0);
    tick(1);
    chk("R10", "pulse default mode", int'(tmr_rst), 1);
    chk("R8", "hiz on pin high", int'(hiz), 1);
    tick(1);
    chk("R10", "pulse ends", int'(tmr_rst), 0);
    chk("R8", "hiz held", int'(hiz), 1);
    dis_pin = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tick(1);
      chk("R10", "no pulse on fall", int'(tmr_rst), 0);
    end
    chk("R8", "hiz released", int'(hiz), 0);
  endtask

  task automatic t_dis_host();
    host_write(1'b0, 0, 1'b0, 0, 1'b1, 1'b0, 1'b0);
    dis_pin = 1'b1;
    tick(3);
    chk("R10", "pulse host mode", int'(tmr_rst), 1);
    chk("R8", "hiz host mode", int'(hiz), 1);
    host_write(1'b0, 0, 1'b0, 0, 1'b1, 1'b0, 1'b0);
    tick(2);
    chk("R9", "pin beats host clear", int'(hiz), 1);
    dis_pin = 1'b0;
    tick(3);
    chk("R8", "hiz released host mode", int'(hiz), 0);
    host_write(1'b0, 0, 1'b0, 0, 1'b1, 1'b1, 1'b0);
    chk("R9", "host bit not yet out", int'(hiz), 0);
    tick(1);
    chk("R9", "host bit drives hiz", int'(hiz), 1);
    expire();
    tick(1);
    chk("R9", "host bit cleared by expiry", int'(hiz), 0);
  endtask

  initial begin
    tick(3);
    t_reset();
    t_strap();
    t_host_own();
    t_expire();
    t_collide();
    t_dis_default();
    t_dis_host();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      vectors++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule